// File: doc/BRIEF.md
# Store-Conditional Aware Miss Entry

This block is one miss-tracking entry of a private cache. The CPU side presents a single operation together with the present state of its line. The entry either completes it at once as a hit or picks one command for the coherence fabric. The command is held in a one-deep queue until the fabric accepts it. While it waits, the entry watches snooped invalidations to the same address. After the command is sent, the entry waits for the fabric's answer and then returns a single-cycle response. The response carries a result bit and an optional new line state for the tag array.

The block treats upgrades that come from a store-conditional differently from ordinary upgrades. A store-conditional upgrade that is beaten by an invalidation while still queued turns into a local fail marker. The marker never reaches the fabric, and the CPU sees result 0. An ordinary upgrade that is beaten the same way is promoted to an exclusive read. Upgrades and writebacks passed down from an upper cache level are also handled here. They are forwarded unchanged when no local copy exists, and they are served locally when a copy exists.

Top module: `scu_miss_entry`

## Requirements
- R1: A write (op 1) or store-conditional (op 2) to a shared line (line 1) issues a plain upgrade (cmd 2) or a store-conditional upgrade (cmd 3) respectively.
- R2: To an invalid line (line 0), a read (op 0) issues a shared read (cmd 0) and a write or store-conditional issues an exclusive read (cmd 1). A read to a shared or writable line, and a write or store-conditional to a writable line (line 2), issue nothing and answer in the cycle after acceptance with result 1 and no state update.
- R3: A snooped invalidation to the entry's address, in a cycle where a queued plain upgrade is not accepted, changes the queued command to an exclusive read.
- R4: The same invalidation on a queued store-conditional upgrade turns it into a fail marker. A fail marker is never presented downstream.
- R5: A fail marker releases the entry with a response of result 0 and no state update, in the cycle after it becomes selected.
- R6: A store-conditional whose upgrade gets an upgrade-fail answer (kind 3) completes with result 0 and no state update.
- R7: An upgrade-fail answer is legal only for a store-conditional upgrade. A plain upgrade ends with an upgrade-ok answer (kind 2) and result 1.
- R8: An upper-level upgrade (op 3) or writeback (op 4) to an invalid line is forwarded unchanged (cmd 2, cmd 4). A forwarded writeback completes when it is accepted. A writeback to a valid line is absorbed at once with update to writable.
- R9: An upper-level upgrade hitting a writable line is acknowledged at once, with the local copy handed off (update to invalid). Any upper-level upgrade that is completed through the fabric also reports update to invalid.
- R10: A store-conditional or write answered by upgrade-ok or exclusive data (kind 1) gives result 1 and update to writable. Shared data (kind 0) gives update to shared.
- R11: `req_ready` is high only while the entry is idle. Each response is a one-cycle `rsp_valid` pulse.
- R12: Once the command has been accepted downstream, an invalidation no longer changes the outcome. An invalidation to another address never changes the queued command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU operation valid |
| req_ready | output | 1 | Entry idle, operation accepted |
| req_op | input | 3 | 0 read, 1 write, 2 store-conditional, 3 upper upgrade, 4 upper writeback |
| req_line | input | 2 | Line state: 0 invalid, 1 shared, 2 writable |
| req_addr | input | AW | Line address |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_result | output | 1 | 0 only for a failed store-conditional |
| rsp_upd | output | 1 | Line state must be written |
| rsp_state | output | 2 | New line state when rsp_upd is high, else 0 |
| ds_valid | output | 1 | Downstream command valid |
| ds_ready | input | 1 | Fabric accepts the command |
| ds_cmd | output | 3 | 0 read, 1 exclusive read, 2 upgrade, 3 store-conditional upgrade, 4 writeback |
| ds_addr | output | AW | Command address |
| dr_valid | input | 1 | Fabric answer valid |
| dr_kind | input | 2 | 0 shared data, 1 exclusive data, 2 upgrade ok, 3 upgrade fail |
| snp_valid | input | 1 | Snooped invalidation |
| snp_addr | input | AW | Invalidated address |

## Verification
The hardest case to reach is the race window. The invalidation has to land while the upgrade sits in the queue and the fabric has not yet accepted it. One cycle later, the same snoop must instead find a command already sent and leave it alone. The stimulus holds `ds_ready` low for a chosen number of cycles. It places the matching or non-matching snoop at a chosen cycle of that hold, on the send cycle, or one cycle after the send. A cycle-accurate behavioural model in the bench predicts every output on every clock.

// File: rtl/scu_pkg.sv
package scu_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_SC    = 3'd2,
    OP_UPFWD = 3'd3,
    OP_WBFWD = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_WRT = 2'd2
  } line_e;

  typedef enum logic [2:0] {
    DC_READ   = 3'd0,
    DC_READEX = 3'd1,
    DC_UPG    = 3'd2,
    DC_SCUPG  = 3'd3,
    DC_WB     = 3'd4,
    DC_FAIL   = 3'd5
  } dcmd_e;

  typedef enum logic [1:0] {
    DR_SHR      = 2'd0,
    DR_EXC      = 2'd1,
    DR_UPG_OK   = 2'd2,
    DR_UPG_FAIL = 2'd3
  } drsp_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_QUEUED = 2'd1,
    S_WAIT   = 2'd2,
    S_RESP   = 2'd3
  } st_e;

  typedef struct packed {
    logic  result;
    logic  upd;
    line_e state;
  } cmpl_t;

  typedef struct packed {
    logic  hit;
    dcmd_e cmd;
    cmpl_t done;
  } plan_t;

  localparam cmpl_t CMPL_OK   = '{result: 1'b1, upd: 1'b0, state: LN_INV};
  localparam cmpl_t CMPL_FAIL = '{result: 1'b0, upd: 1'b0, state: LN_INV};

  function automatic plan_t plan_op(op_e op, line_e ln);
    plan_t p;
    p.hit  = 1'b0;
    p.cmd  = DC_READ;
    p.done = CMPL_OK;
    case (op)
      OP_READ: begin
        if (ln == LN_SHR || ln == LN_WRT) p.hit = 1'b1;
        else                              p.cmd = DC_READ;
      end
      OP_WRITE, OP_SC: begin
        if (ln == LN_WRT)      p.hit = 1'b1;
        else if (ln == LN_SHR) p.cmd = (op == OP_SC) ? DC_SCUPG : DC_UPG;
        else                   p.cmd = DC_READEX;
      end
      OP_UPFWD: begin
        if (ln == LN_WRT) begin
          p.hit  = 1'b1;
          p.done = '{result: 1'b1, upd: 1'b1, state: LN_INV};
        end else begin
          p.cmd = DC_UPG;
        end
      end
      OP_WBFWD: begin
        if (ln == LN_SHR || ln == LN_WRT) begin
          p.hit  = 1'b1;
          p.done = '{result: 1'b1, upd: 1'b1, state: LN_WRT};
        end else begin
          p.cmd = DC_WB;
        end
      end
      default: p.cmd = DC_READ;
    endcase
    return p;
  endfunction

  function automatic cmpl_t answer_outcome(op_e op, drsp_e kind);
    cmpl_t c;
    case (kind)
      DR_SHR:      c = '{result: 1'b1, upd: 1'b1, state: LN_SHR};
      DR_UPG_FAIL: c = CMPL_FAIL;
      default:     c = '{result: 1'b1, upd: 1'b1,
                         state: (op == OP_UPFWD) ? LN_INV : LN_WRT};
    endcase
    return c;
  endfunction

  function automatic dcmd_e after_invalidate(dcmd_e cmd);
    case (cmd)
      DC_UPG:   return DC_READEX;
      DC_SCUPG: return DC_FAIL;
      default:  return cmd;
    endcase
  endfunction

endpackage

// File: rtl/scu_decode.sv
module scu_decode
  import scu_pkg::*;
(
  input  logic [2:0] op,
  input  logic [1:0] line,
  output plan_t      plan
);
  always_comb plan = plan_op(op_e'(op), line_e'(line));
endmodule

// File: rtl/scu_queue.sv
module scu_queue
  import scu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  dcmd_e load_cmd,
  input  logic  active,
  input  logic  sent,
  input  logic  snp_hit,
  output dcmd_e cmd_q,
  output logic  ev_rw_ex,
  output logic  ev_rw_fail
);
  logic window;

  assign window     = active && !sent && snp_hit;
  assign ev_rw_ex   = window && (cmd_q == DC_UPG);
  assign ev_rw_fail = window && (cmd_q == DC_SCUPG);

  always_ff @(posedge clk) begin
    if (!rst_n)                     cmd_q <= DC_READ;
    else if (load)                  cmd_q <= load_cmd;
    else if (ev_rw_ex || ev_rw_fail) cmd_q <= after_invalidate(cmd_q);
  end

  AST_UPG_BECOMES_READEX: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sent && snp_hit && cmd_q == DC_UPG) |=> (cmd_q == DC_READEX)); // R3
  AST_SCUPG_BECOMES_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sent && snp_hit && cmd_q == DC_SCUPG) |=> (cmd_q == DC_FAIL)); // R4
  AST_SENT_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sent) |=> $stable(cmd_q)); // R12
endmodule

// File: rtl/scu_finish.sv
module scu_finish
  import scu_pkg::*;
(
  input  logic  sel_hit,
  input  logic  sel_fail,
  input  logic  sel_wb,
  input  cmpl_t hit_done,
  input  op_e   op,
  input  drsp_e kind,
  output cmpl_t done
);
  always_comb begin
    if (sel_hit)       done = hit_done;
    else if (sel_fail) done = CMPL_FAIL;
    else if (sel_wb)   done = CMPL_OK;
    else               done = answer_outcome(op, kind);
  end
endmodule

// File: rtl/scu_miss_entry.sv
module scu_miss_entry
  import scu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [1:0]    req_line,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic          rsp_result,
  output logic          rsp_upd,
  output logic [1:0]    rsp_state,
  output logic          ds_valid,
  input  logic          ds_ready,
  output logic [2:0]    ds_cmd,
  output logic [AW-1:0] ds_addr,
  input  logic          dr_valid,
  input  logic [1:0]    dr_kind,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr
);
  st_e           st;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  dcmd_e         cmd_q;
  cmpl_t         rsp_q;
  plan_t         plan;
  cmpl_t         done;

  // named internal events
  logic ev_accept, ev_send, ev_fail_local, ev_answer, ev_finish;
  logic ev_rw_ex, ev_rw_fail, snp_hit, queued;

  scu_decode u_dec (.op(req_op), .line(req_line), .plan(plan));

  assign queued        = (st == S_QUEUED);
  assign ev_accept     = req_valid && req_ready;
  assign ev_fail_local = queued && (cmd_q == DC_FAIL);
  assign ev_send       = ds_valid && ds_ready;
  assign ev_answer     = (st == S_WAIT) && dr_valid;
  assign snp_hit       = snp_valid && (snp_addr == addr_q);
  assign ev_finish     = (ev_accept && plan.hit) || ev_fail_local ||
                         (ev_send && cmd_q == DC_WB) || ev_answer;

  scu_queue u_q (
    .clk(clk), .rst_n(rst_n),
    .load(ev_accept && !plan.hit), .load_cmd(plan.cmd),
    .active(queued), .sent(ev_send), .snp_hit(snp_hit),
    .cmd_q(cmd_q), .ev_rw_ex(ev_rw_ex), .ev_rw_fail(ev_rw_fail)
  );

  scu_finish u_fin (
    .sel_hit(st == S_IDLE), .sel_fail(ev_fail_local),
    .sel_wb(queued && cmd_q == DC_WB), .hit_done(plan.done),
    .op(op_q), .kind(drsp_e'(dr_kind)), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_READ;
      addr_q <= '0;
      rsp_q  <= CMPL_OK;
    end else begin
      if (ev_finish) rsp_q <= done;
      case (st)
        S_IDLE: if (ev_accept) begin
          op_q   <= op_e'(req_op);
          addr_q <= req_addr;
          st     <= plan.hit ? S_RESP : S_QUEUED;
        end
        S_QUEUED: begin
          if (ev_fail_local)                   st <= S_RESP;
          else if (ev_send && cmd_q == DC_WB)  st <= S_RESP;
          else if (ev_send)                    st <= S_WAIT;
        end
        S_WAIT:  if (dr_valid) st <= S_RESP;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign ds_valid   = queued && (cmd_q != DC_FAIL);
  assign ds_cmd     = cmd_q;
  assign ds_addr    = addr_q;
  assign rsp_valid  = (st == S_RESP);
  assign rsp_result = rsp_q.result;
  assign rsp_upd    = rsp_q.upd;
  assign rsp_state  = rsp_q.state;

  AST_FAIL_MARKER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (queued && cmd_q == DC_FAIL) |=> (rsp_valid && !rsp_result && !rsp_upd)); // R5
  AST_SC_FAIL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && dr_valid && dr_kind == DR_UPG_FAIL) |=> (rsp_valid && !rsp_result && !rsp_upd)); // R6
  AST_UPGFAIL_ONLY_SC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && dr_valid && dr_kind == DR_UPG_FAIL) |-> (cmd_q == DC_SCUPG)); // R7
  AST_HANDOFF_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_UPFWD) |-> (rsp_upd && rsp_state == LN_INV)); // R9
  AST_SC_OK_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && dr_valid && dr_kind == DR_UPG_OK && op_q == OP_SC) |=> (rsp_result && rsp_state == LN_WRT)); // R10
  AST_RSP_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11
  AST_WAIT_NO_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |=> $stable(cmd_q)); // R12
  AST_DS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && !ds_ready && !snp_hit) |=> (ds_valid && $stable(ds_cmd))); // R1
endmodule

// File: tb/sim_scu_miss_entry.sv
module sim_scu_miss_entry;
  localparam int AW = 32;
  localparam logic [AW-1:0] A = 32'h0000_0040;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, ds_ready = 1'b0, dr_valid = 1'b0, snp_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [1:0] req_line = '0, dr_kind = '0;
  logic [AW-1:0] req_addr = '0, snp_addr = '0;
  logic req_ready, rsp_valid, rsp_result, rsp_upd, ds_valid;
  logic [1:0] rsp_state;
  logic [2:0] ds_cmd;
  logic [AW-1:0] ds_addr;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R11";

  // behavioural model state
  int m_ph = 0, m_cmd = 0, m_op = 0, m_res = 1, m_upd = 0, m_st = 0;
  logic [AW-1:0] m_addr = '0;

  always #4 clk = ~clk; // 125 MHz

  scu_miss_entry #(.AW(AW)) u0 (.*);

  task automatic chk(string t, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", t, what, act, exp, $time);
    end
  endtask

  // expectation rules restated from the requirements
  always @(posedge clk) begin
    if (!rst_n) m_ph = 0;
    else begin
      case (m_ph)
        0: if (req_valid) begin
          int o, l, hit;
          o = req_op; l = req_line; hit = 0;
          m_op = o; m_addr = req_addr; m_res = 1; m_upd = 0; m_st = 0;
          if (o == 0) begin hit = (l == 1 || l == 2); m_cmd = 0; end
          else if (o == 1 || o == 2) begin
            hit = (l == 2);
            m_cmd = (l == 1) ? ((o == 2) ? 3 : 2) : 1;
          end else if (o == 3) begin
            hit = (l == 2); m_cmd = 2;
            if (hit) begin m_upd = 1; m_st = 0; end
          end else begin
            hit = (l == 1 || l == 2); m_cmd = 4;
            if (hit) begin m_upd = 1; m_st = 2; end
          end
          m_ph = hit ? 3 : 1;
        end
        1: begin
          if (m_cmd == 5) begin m_res = 0; m_upd = 0; m_st = 0; m_ph = 3; end
          else if (ds_ready) begin
            if (m_cmd == 4) begin m_res = 1; m_upd = 0; m_st = 0; m_ph = 3; end
            else m_ph = 2;
          end else if (snp_valid && snp_addr == m_addr) begin
            if (m_cmd == 2) m_cmd = 1;
            else if (m_cmd == 3) m_cmd = 5;
          end
        end
        2: if (dr_valid) begin
          m_ph = 3;
          if (dr_kind == 3) begin m_res = 0; m_upd = 0; m_st = 0; end
          else begin
            m_res = 1; m_upd = 1;
            m_st = (dr_kind == 0) ? 1 : ((m_op == 3) ? 0 : 2);
          end
        end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R11", int'(req_ready), int'(m_ph == 0), "req_ready");
    chk(tag, int'(ds_valid), int'(m_ph == 1 && m_cmd != 5), "ds_valid");
    if (m_ph == 1 && m_cmd != 5) begin
      chk(tag, int'(ds_cmd), m_cmd, "ds_cmd");
      chk(tag, int'(ds_addr == m_addr), 1, "ds_addr");
    end
    chk(tag, int'(rsp_valid), int'(m_ph == 3), "rsp_valid");
    if (m_ph == 3) begin
      chk(tag, int'(rsp_result), m_res, "rsp_result");
      chk(tag, int'(rsp_upd), m_upd, "rsp_upd");
      chk(tag, int'(rsp_state), m_st, "rsp_state");
    end
  end

  // hold: queued cycles with ds_ready low; snp_at: cycle index of snoop
  // (hold = send cycle, hold+1 = cycle after send); kind: fabric answer
  task automatic scen(string t, int op, int line, int hold, int snp_at,
                      bit snp_match, int kind);
    tag = t;
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_line = 2'(line); req_addr = A;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i <= hold + 1; i++) begin
      ds_ready  = (i == hold);
      snp_valid = (i == snp_at);
      snp_addr  = snp_match ? A : (A ^ 32'h40);
      @(negedge clk);
    end
    ds_ready = 1'b0; snp_valid = 1'b0;
    dr_valid = 1'b1; dr_kind = 2'(kind);
    @(negedge clk);
    dr_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", int'(rsp_valid), 0, "reset rsp_valid");
    chk("R11", int'(ds_valid), 0, "reset ds_valid");
    rst_n = 1'b1;
    scen("R2",  0, 0, 1, -1, 1, 0);   // read miss, shared fill
    scen("R2",  0, 1, 0, -1, 1, 0);   // read hit
    scen("R2",  2, 2, 0, -1, 1, 0);   // store-conditional hit
    scen("R2",  1, 0, 2, -1, 1, 1);   // write miss, exclusive read
    scen("R1",  1, 1, 2, -1, 1, 2);   // plain upgrade
    scen("R10", 2, 1, 1, -1, 1, 2);   // sc upgrade ok
    scen("R7",  1, 1, 0, -1, 1, 2);   // plain upgrade ends ok
    scen("R3",  1, 1, 3, 1, 1, 1);    // upgrade beaten, exclusive read
    scen("R4",  2, 1, 3, 0, 1, 1);    // sc upgrade beaten
    scen("R5",  2, 1, 2, 1, 1, 2);    // fail marker, answer ignored
    scen("R6",  2, 1, 1, -1, 1, 3);   // sc upgrade fail answer
    scen("R12", 2, 1, 2, 2, 1, 2);    // snoop on send cycle
    scen("R12", 2, 1, 1, 2, 1, 2);    // snoop after send
    scen("R12", 2, 1, 2, 0, 0, 2);    // snoop other address
    scen("R8",  3, 0, 1, -1, 1, 2);   // upper upgrade forwarded
    scen("R8",  4, 0, 2, -1, 1, 0);   // writeback forwarded
    scen("R8",  4, 1, 0, -1, 1, 0);   // writeback absorbed
    scen("R9",  3, 2, 0, -1, 1, 0);   // upper upgrade handoff
    scen("R9",  3, 1, 1, 0, 1, 1);    // upper upgrade via fabric
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end
endmodule